// File: doc/BRIEF.md
# Load/Store Issue Gate

This block arbitrates the fate of the oldest translated memory request in a load/store unit. Every cycle it inspects the flags of that request together with a handful of pipeline status signals, and it names exactly one outcome. The outcome is one of these: wait, drop the request as squashed, pass it on carrying its fault, pass on a faulted prefetch quietly, route a committed store towards the store buffer, satisfy a load from store-buffer data, or start a real memory access. The queues, the store buffer and the memory port stay outside the block. The surrounding logic acts on the one-hot action word.

The rules form a fixed priority chain. Retry and translation state come first, then space downstream, then squash, then faults, then the ordering rules. An access counts as bufferable unless it is strictly ordered, a load-linked/store-conditional, a swap, an atomic or a release. The decision is computed combinationally and registered, so the action for the inputs seen at one clock edge appears on `action` right after that edge.

Top module: `lsgate_top`

## Requirements
- R1: While reset is asserted, and in any cycle after an edge at which `head_valid` was low, `action` is all zeros.
- R2: If `retry_pending` or `in_translation` is high, the action is stall. This rule takes priority over every rule below it.
- R3: If `xfer_space` is low, the action is stall.
- R4: A request with `wrong_stream` high stalls while `pkts_in_mem` is high, and is aborted otherwise.
- R5: A request with `has_fault` high becomes a quiet completion when `is_prefetch` is high, and a faulted pass-on otherwise.
- R6: A load (`is_load` high) stalls while `stores_in_xfer` is non-zero, whatever its bufferability.
- R7: A store that is bufferable (none of `strict_order`, `llsc`, `swap`, `atomic`, `release_acc` high) and has `local_access` low goes to the store buffer. It does not issue.
- R8: A store with `llsc` high, or any access with `release_acc` high, stalls while `sb_empty` is low.
- R9: A non-bufferable access stalls unless `is_head_inst` is high.
- R10: For a load, `fwd_cov` selects the result. 2'b10 (full coverage) takes forwarded data. 2'b01 (partial) and 2'b11 stall. 2'b00 (none) goes on to the issue rule.
- R11: A request that reaches the issue rule issues when `mem_inflight` < `MAX_INFLIGHT` and stalls otherwise. `MAX_INFLIGHT` must be at least 1.
- R12: `action` is one-hot after an edge with `head_valid` high. The bit positions are: 0 stall, 1 abort, 2 fault pass-on, 3 quiet completion, 4 to store buffer, 5 forward, 6 issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A request sits at the head |
| retry_pending | input | 1 | Memory port awaits a retry |
| in_translation | input | 1 | Head request not yet translated |
| xfer_space | input | 1 | Transfers queue has unreserved space |
| wrong_stream | input | 1 | Head request belongs to a squashed stream |
| pkts_in_mem | input | 1 | Head request has packets in the memory system |
| has_fault | input | 1 | Translation fault recorded |
| is_prefetch | input | 1 | Request comes from a prefetch |
| is_load | input | 1 | Load (1) or store (0) |
| strict_order | input | 1 | Strictly ordered access |
| llsc | input | 1 | Load-linked or store-conditional |
| swap | input | 1 | Swap access |
| atomic | input | 1 | Atomic read-modify-write |
| release_acc | input | 1 | Release-ordered access |
| local_access | input | 1 | Access handled inside the core |
| is_head_inst | input | 1 | Instruction is the oldest in flight |
| stores_in_xfer | input | CNT_W | Stores currently in the transfers queue |
| sb_empty | input | 1 | Store buffer holds nothing |
| fwd_cov | input | 2 | Store-buffer coverage of the load |
| mem_inflight | input | INF_W | Accesses outstanding in memory |
| action | output | 7 | Registered one-hot action |

## Verification
Several rules can claim the same cycle. The bench provokes these collisions on purpose. In one case a squashed request also carries a fault. In another, a load with full forwarding coverage meets queued stores. In a third, a store-conditional is bufferable-excluded yet not at the head while the store buffer is busy. In a fourth, an issuable request meets a full in-flight count. In each case the single registered bit must be the one the highest-priority rule names. A behavioural model in the bench evaluates the same rule list from the previous cycle's inputs and compares the whole action word every clock. This is done for directed collisions and for biased random traffic.

// File: rtl/lsgate_pkg.sv
package lsgate_pkg;
    localparam int NACT = 7;

    typedef enum int {
        ACT_STALL = 0,
        ACT_ABORT = 1,
        ACT_FAULT = 2,
        ACT_QUIET = 3,
        ACT_TOSB  = 4,
        ACT_FWD   = 5,
        ACT_ISSUE = 6
    } act_idx_e;

    typedef enum logic [1:0] {
        COV_NONE = 2'b00,
        COV_PART = 2'b01,
        COV_FULL = 2'b10,
        COV_RSVD = 2'b11
    } cov_e;

    typedef struct packed {
        logic is_load;
        logic strict_order;
        logic llsc;
        logic swap;
        logic atomic;
        logic release_acc;
        logic local_access;
    } attr_t;

    typedef struct packed {
        logic            bufferable;
        logic            sb_bound;
        logic            needs_drain;
    } cls_t;
endpackage

// File: rtl/lsgate_attr.sv
module lsgate_attr
    import lsgate_pkg::*;
(
    input  attr_t attr,
    output cls_t  cls
);
    always_comb begin
        cls.bufferable  = !(attr.strict_order || attr.llsc || attr.swap ||
                            attr.atomic || attr.release_acc);
        cls.sb_bound    = cls.bufferable && !attr.is_load && !attr.local_access;
        cls.needs_drain = (!attr.is_load && attr.llsc) || attr.release_acc;
    end
endmodule

// File: rtl/lsgate_prio.sv
module lsgate_prio
    import lsgate_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    parameter int CNT_W        = 4,
    parameter int INF_W        = 3
) (
    input  logic             head_valid,
    input  logic             retry_pending,
    input  logic             in_translation,
    input  logic             xfer_space,
    input  logic             wrong_stream,
    input  logic             pkts_in_mem,
    input  logic             has_fault,
    input  logic             is_prefetch,
    input  logic             is_load,
    input  cls_t             cls,
    input  logic             is_head_inst,
    input  logic [CNT_W-1:0] stores_in_xfer,
    input  logic             sb_empty,
    input  logic [1:0]       fwd_cov,
    input  logic [INF_W-1:0] mem_inflight,
    output logic [NACT-1:0]  act
);
    localparam int unsigned LIMIT = MAX_INFLIGHT;

    always_comb begin
        act = '0;
        if (!head_valid) begin
            act = '0;
        end else if (retry_pending || in_translation || !xfer_space) begin
            act[ACT_STALL] = 1'b1;
        end else if (wrong_stream) begin
            if (pkts_in_mem) act[ACT_STALL] = 1'b1;
            else             act[ACT_ABORT] = 1'b1;
        end else if (has_fault) begin
            if (is_prefetch) act[ACT_QUIET] = 1'b1;
            else             act[ACT_FAULT] = 1'b1;
        end else if (is_load && (stores_in_xfer != '0)) begin
            act[ACT_STALL] = 1'b1;
        end else if (cls.sb_bound) begin
            act[ACT_TOSB] = 1'b1;
        end else if (cls.needs_drain && !sb_empty) begin
            act[ACT_STALL] = 1'b1;
        end else if (!cls.bufferable && !is_head_inst) begin
            act[ACT_STALL] = 1'b1;
        end else if (is_load && (fwd_cov == COV_FULL)) begin
            act[ACT_FWD] = 1'b1;
        end else if (is_load && (fwd_cov != COV_NONE)) begin
            act[ACT_STALL] = 1'b1;
        end else if (32'(mem_inflight) >= LIMIT) begin
            act[ACT_STALL] = 1'b1;
        end else begin
            act[ACT_ISSUE] = 1'b1;
        end
    end
endmodule

// File: rtl/lsgate_top.sv
module lsgate_top
    import lsgate_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    parameter int XFER_DEPTH   = 8,
    localparam int CNT_W       = $clog2(XFER_DEPTH + 1),
    localparam int INF_W       = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic             retry_pending,
    input  logic             in_translation,
    input  logic             xfer_space,
    input  logic             wrong_stream,
    input  logic             pkts_in_mem,
    input  logic             has_fault,
    input  logic             is_prefetch,
    input  logic             is_load,
    input  logic             strict_order,
    input  logic             llsc,
    input  logic             swap,
    input  logic             atomic,
    input  logic             release_acc,
    input  logic             local_access,
    input  logic             is_head_inst,
    input  logic [CNT_W-1:0] stores_in_xfer,
    input  logic             sb_empty,
    input  logic [1:0]       fwd_cov,
    input  logic [INF_W-1:0] mem_inflight,
    output logic [NACT-1:0]  action
);
    generate
        if (MAX_INFLIGHT < 1) begin : g_bad_limit
            $error("MAX_INFLIGHT must be at least 1");
        end
    endgenerate

    typedef struct packed {
        logic [NACT-1:0] act;
        logic            live;
    } reg_t;

    reg_t  st_d, st_q;
    attr_t attr;
    cls_t  cls;
    logic [NACT-1:0] act_c;

    assign attr = '{is_load: is_load, strict_order: strict_order, llsc: llsc,
                    swap: swap, atomic: atomic, release_acc: release_acc,
                    local_access: local_access};

    lsgate_attr u_attr (.attr(attr), .cls(cls));

    lsgate_prio #(
        .MAX_INFLIGHT(MAX_INFLIGHT), .CNT_W(CNT_W), .INF_W(INF_W)
    ) u_prio (
        .head_valid(head_valid), .retry_pending(retry_pending),
        .in_translation(in_translation), .xfer_space(xfer_space),
        .wrong_stream(wrong_stream), .pkts_in_mem(pkts_in_mem),
        .has_fault(has_fault), .is_prefetch(is_prefetch), .is_load(is_load),
        .cls(cls), .is_head_inst(is_head_inst), .stores_in_xfer(stores_in_xfer),
        .sb_empty(sb_empty), .fwd_cov(fwd_cov), .mem_inflight(mem_inflight),
        .act(act_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.act  = act_c;
        st_d.live = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign action = st_q.act;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> action == '0);
    assert_no_head_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && $past(!head_valid) |-> action == '0);
    assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && $past(head_valid) |-> $countones(action) == 1);
    assert_retry_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && $past(head_valid && (retry_pending || in_translation))
        |-> action[ACT_STALL]);
    assert_abort_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && action[ACT_ABORT] |-> $past(wrong_stream && !pkts_in_mem));
    assert_load_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && $past(is_load && stores_in_xfer != '0)
        |-> !action[ACT_ISSUE] && !action[ACT_FWD]);
    assert_tosb_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && action[ACT_TOSB] |-> $past(!is_load && !local_access));
    assert_inflight_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live && action[ACT_ISSUE] |-> $past(32'(mem_inflight) < MAX_INFLIGHT));
endmodule

// File: tb/lsgate_top_tb_top.sv
module lsgate_top_tb_top;
    localparam int MAXF  = 4;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int IW    = $clog2(MAXF + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hv, rp, it, xs, ws, pm, hf, pf, ld, so, ll, sw, at, rl, la, hi, se;
    logic [CW-1:0] six;
    logic [1:0]    fc;
    logic [IW-1:0] mi;
    logic [6:0]    action;

    int n_tests = 0;
    int n_fail  = 0;
    logic [6:0] exp_q;
    string      req_q;

    always #2.5 clk = ~clk;

    lsgate_top #(.MAX_INFLIGHT(MAXF), .XFER_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .head_valid(hv), .retry_pending(rp),
        .in_translation(it), .xfer_space(xs), .wrong_stream(ws),
        .pkts_in_mem(pm), .has_fault(hf), .is_prefetch(pf), .is_load(ld),
        .strict_order(so), .llsc(ll), .swap(sw), .atomic(at), .release_acc(rl),
        .local_access(la), .is_head_inst(hi), .stores_in_xfer(six),
        .sb_empty(se), .fwd_cov(fc), .mem_inflight(mi), .action(action)
    );

    // behavioural reference: returns action word, reports deciding rule
    function automatic logic [6:0] model(output string r);
        bit buf_ok;
        buf_ok = !(so || ll || sw || at || rl);
        r = "R12";
        if (!hv) begin r = "R1"; return 7'd0; end
        if (rp || it) begin r = "R2"; return 7'b0000001; end
        if (!xs) begin r = "R3"; return 7'b0000001; end
        if (ws) begin r = "R4"; return pm ? 7'b0000001 : 7'b0000010; end
        if (hf) begin r = "R5"; return pf ? 7'b0001000 : 7'b0000100; end
        if (ld && six != 0) begin r = "R6"; return 7'b0000001; end
        if (!ld && buf_ok && !la) begin r = "R7"; return 7'b0010000; end
        if (((!ld && ll) || rl) && !se) begin r = "R8"; return 7'b0000001; end
        if (!buf_ok && !hi) begin r = "R9"; return 7'b0000001; end
        if (ld && fc == 2'b10) begin r = "R10"; return 7'b0100000; end
        if (ld && fc != 2'b00) begin r = "R10"; return 7'b0000001; end
        r = "R11";
        if (int'(mi) >= MAXF) return 7'b0000001;
        return 7'b1000000;
    endfunction

    task automatic idle();
        {hv, rp, it, xs, ws, pm, hf, pf, ld, so, ll, sw, at, rl, la, hi, se} = '0;
        six = '0; fc = 2'b00; mi = '0;
    endtask

    // base: valid, translated, space, head, sb empty, nothing queued
    task automatic base();
        idle();
        hv = 1; xs = 1; hi = 1; se = 1;
    endtask

    task automatic check(input string tag, input logic [6:0] exp);
        n_tests++;
        if (action !== exp) begin
            n_fail++;
            $display("FAIL %s: action=%b expected=%b", tag, action, exp);
        end
    endtask

    // apply inputs at negedge, compare at following negedge
    task automatic step();
        string r;
        exp_q = model(r);
        req_q = r;
        @(negedge clk);
        check(req_q, exp_q);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: action=%b expected=done", action);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        idle();
        hv = 1; ld = 1; xs = 1;
        repeat (3) @(negedge clk);
        check("R1", 7'd0);
        rst_n = 1;
        idle();
        @(negedge clk);
        base(); ld = 1; mi = IW'(MAXF);  step();              // R11 at limit
        base(); ld = 1; mi = IW'(MAXF-1); step();             // R11 issue
        base(); rp = 1; hf = 1; step();                        // R2 over fault
        base(); it = 1; step();                                // R2
        base(); xs = 0; ws = 1; step();                        // R3
        base(); ws = 1; hf = 1; step();                        // R4 abort beats fault
        base(); ws = 1; pm = 1; step();                        // R4 stall
        base(); hf = 1; pf = 1; step();                        // R5 quiet
        base(); hf = 1; step();                                // R5 fault
        base(); ld = 1; six = 1; fc = 2'b10; step();           // R6 over forward
        base(); ld = 1; so = 1; six = CW'(DEPTH); step();      // R6 non-bufferable
        base(); hi = 0; mi = IW'(MAXF); step();                // R7 store to sb
        base(); la = 1; step();                                // R7 local: issue
        base(); ll = 1; se = 0; step();                        // R8 stcond drain
        base(); ld = 1; rl = 1; se = 0; step();                // R8 release load
        base(); ld = 1; ll = 1; se = 0; step();                // R8 not for ll load
        base(); at = 1; hi = 0; step();                        // R9
        base(); ld = 1; fc = 2'b10; mi = IW'(MAXF); step();    // R10 full
        base(); ld = 1; fc = 2'b01; step();                    // R10 partial
        base(); ld = 1; fc = 2'b11; step();                    // R10 reserved
        base(); hv = 0; hf = 1; step();                        // R1
        for (int i = 0; i < 4000; i++) begin
            hv  = ($urandom % 10) != 0;
            rp  = ($urandom % 12) == 0;
            it  = ($urandom % 12) == 0;
            xs  = ($urandom % 10) != 0;
            ws  = ($urandom % 10) == 0;
            pm  = $urandom % 2;
            hf  = ($urandom % 10) == 0;
            pf  = $urandom % 2;
            ld  = $urandom % 2;
            so  = ($urandom % 8) == 0;
            ll  = ($urandom % 8) == 0;
            sw  = ($urandom % 10) == 0;
            at  = ($urandom % 10) == 0;
            rl  = ($urandom % 8) == 0;
            la  = ($urandom % 5) == 0;
            hi  = ($urandom % 4) != 0;
            se  = $urandom % 2;
            six = (($urandom % 3) == 0) ? CW'($urandom % (DEPTH + 1)) : '0;
            fc  = 2'($urandom);
            mi  = IW'($urandom % (MAXF + 1));
            step();
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule